// File: doc/BRIEF.md
# Adjacent-Wire Coupling Cost Accumulator

This block sits beside a parallel bus and measures how much switching activity couples between wires that lie next to each other on silicon. Whenever a valid word arrives, it compares that word with the previous valid word. Every neighbouring pair of physical tracks is then charged a weighted cost. The weight depends on how the two wires moved together, not on a plain toggle count. A wire that switches next to a quiet neighbour costs one unit. Two wires that rise or fall together cost nothing. Two wires that move against each other cost four units.

A compile-time map sets which logical bit runs on which physical track, so a candidate wire ordering can be scored against real traffic. Costs build up in one saturating counter per pair and in a grand total. A registered read port returns any pair's counter, and a clear pulse restarts the measurement.

Top module: `coupling_monitor`

## Requirements
- R1: After reset, every pair counter, the total and the read output are zero.
- R2: A pair in which exactly one of the two wires changes while the other holds is charged 1.
- R3: A pair in which both wires change in the same direction (both rise or both fall) is charged 0.
- R4: A pair in which both wires change in opposite directions (one rises while the other falls) is charged 4.
- R5: A pair in which neither wire changes is charged 0. A cycle with `in_valid` low changes no counter and does not replace the stored previous word.
- R6: The first valid word after reset or clear is stored and charges nothing.
- R7: Physical track t carries logical bit `TRACK_MAP[8t+7:8t]`, and pair p is tracks p and p+1. A map whose fields are all 0xFF selects the natural order.
- R8: Each pair counter saturates at its all-ones value and never wraps.
- R9: `total_cost` grows each charged cycle by the sum of that cycle's pair costs over all N−1 pairs. It wraps modulo 2^TOT_W.
- R10: A `clear` cycle zeroes all counters, the total and the stored word by the next edge. A word that is valid in the same cycle is dropped.
- R11: `rd_cost` presents the counter of pair `rd_idx` one cycle after the index, as it stood before that edge. An index of N−1 or more reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_word` this cycle |
| in_word | input | BUS_W | Observed bus word, in logical bit order |
| clear | input | 1 | Synchronous restart of all accumulation |
| rd_idx | input | IDX_W | Pair selected for readout |
| rd_cost | output | CNT_W | Registered counter of the selected pair |
| total_cost | output | TOT_W | Accumulated cost over all pairs |

## Verification
A corrupted stored word or a lost first-word flag shows up as a wrong total on the very next valid word. For that reason, every word pair of a small four-wire configuration is played from a fresh clear, and both the total and each pair counter are compared right after the second word. A wrong track map, or a swapped pair, shows as a cost landing on the wrong counter one read cycle later. Saturation or wrap faults only appear after long accumulation, so a stream of several hundred words with idle cycles mixed in is compared against an arithmetic model at the end.

// File: rtl/coupling_pkg.sv
package coupling_pkg;
  localparam int unsigned MAP_FIELD_W = 8;
  localparam int unsigned COST_W      = 3;

  // Joint-transition weight of one adjacent track pair.
  function automatic logic [COST_W-1:0] pair_cost(input logic old_lo, input logic old_hi,
                                                   input logic new_lo, input logic new_hi);
    logic tog_lo;
    logic tog_hi;
    tog_lo = old_lo ^ new_lo;
    tog_hi = old_hi ^ new_hi;
    if (tog_lo && tog_hi) begin
      return (old_lo == old_hi) ? COST_W'(0) : COST_W'(4);
    end
    if (tog_lo || tog_hi) begin
      return COST_W'(1);
    end
    return COST_W'(0);
  endfunction
endpackage

// File: rtl/coupling_track_map.sv
module coupling_track_map
  import coupling_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter logic [BUS_W*MAP_FIELD_W-1:0] TRACK_MAP = '1
) (
  input  logic [BUS_W-1:0] logical_word,
  output logic [BUS_W-1:0] track_word
);
  localparam logic [BUS_W*MAP_FIELD_W-1:0] NATURAL_CODE = '1;
  localparam bit USE_NATURAL = (TRACK_MAP == NATURAL_CODE);

  for (genvar t = 0; t < BUS_W; t++) begin : g_track
    localparam int SRC = USE_NATURAL ? t : int'(TRACK_MAP[t*MAP_FIELD_W +: MAP_FIELD_W]);
    assign track_word[t] = logical_word[SRC];
  end
endmodule

// File: rtl/coupling_pair_counter.sv
module coupling_pair_counter
  import coupling_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [COST_W-1:0] cost,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + {{(CNT_W+1-COST_W){1'b0}}, cost};
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}} && !clr) |=> (cnt_q == {CNT_W{1'b1}}));
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q >= $past(cnt_q)));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/coupling_monitor.sv
module coupling_monitor
  import coupling_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned CNT_W = 32,
  parameter int unsigned TOT_W = 40,
  parameter logic [BUS_W*MAP_FIELD_W-1:0] TRACK_MAP = '1,
  localparam int unsigned NPAIR = BUS_W - 1,
  localparam int unsigned IDX_W = $clog2(NPAIR + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [BUS_W-1:0] in_word,
  input  logic             clear,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cost,
  output logic [TOT_W-1:0] total_cost
);
  localparam int unsigned SUM_W = $clog2(4 * NPAIR + 1);

  logic [BUS_W-1:0]  track_now;
  logic [BUS_W-1:0]  prev_q;
  logic [BUS_W-1:0]  prev_d;
  logic              have_prev_q;
  logic              have_prev_d;
  logic              charge;
  logic [COST_W-1:0] cost_w [NPAIR];
  logic [CNT_W-1:0]  cnt_w  [NPAIR];
  logic [SUM_W-1:0]  cycle_sum;
  logic [TOT_W-1:0]  total_q;
  logic [TOT_W-1:0]  total_d;
  logic [CNT_W-1:0]  rd_q;
  logic [CNT_W-1:0]  rd_d;

  coupling_track_map #(.BUS_W(BUS_W), .TRACK_MAP(TRACK_MAP)) u_map (
    .logical_word(in_word),
    .track_word  (track_now)
  );

  assign charge = in_valid && have_prev_q && !clear;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign cost_w[p] = pair_cost(prev_q[p], prev_q[p+1], track_now[p], track_now[p+1]);

    coupling_pair_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clear),
      .en   (charge),
      .cost (cost_w[p]),
      .count(cnt_w[p])
    );
  end

  always_comb begin
    cycle_sum = '0;
    for (int p = 0; p < NPAIR; p++) begin
      cycle_sum = cycle_sum + SUM_W'(cost_w[p]);
    end
  end

  always_comb begin
    prev_d      = prev_q;
    have_prev_d = have_prev_q;
    total_d     = total_q;
    if (clear) begin
      prev_d      = '0;
      have_prev_d = 1'b0;
      total_d     = '0;
    end else if (in_valid) begin
      prev_d      = track_now;
      have_prev_d = 1'b1;
      if (charge) begin
        total_d = total_q + TOT_W'(cycle_sum);
      end
    end
    rd_d = '0;
    if (32'(rd_idx) < NPAIR) begin
      rd_d = cnt_w[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      total_q     <= '0;
      rd_q        <= '0;
    end else begin
      prev_q      <= prev_d;
      have_prev_q <= have_prev_d;
      total_q     <= total_d;
      rd_q        <= rd_d;
    end
  end

  assign rd_cost    = rd_q;
  assign total_cost = total_q;

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clear) |=> $stable(total_q));
  assert_first_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!have_prev_q && !clear) |=> $stable(total_q));
  assert_total_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((total_q - $past(total_q)) <= TOT_W'(4 * NPAIR)));
  assert_clear_total_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (total_q == '0 && !have_prev_q));
  assert_rd_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_idx) >= NPAIR) |=> (rd_q == '0));
endmodule

// File: tb/coupling_monitor_test.sv
`timescale 1ns/100ps
module coupling_monitor_test;
  localparam int BUS_W = 4;
  localparam int CNT_W = 6;
  localparam int TOT_W = 16;
  localparam int NPAIR = BUS_W - 1;
  localparam int CMAX  = (1 << CNT_W) - 1;
  // physical tracks 0..3 carry logical bits 2,0,3,1
  localparam logic [BUS_W*8-1:0] MAP = {8'd1, 8'd3, 8'd0, 8'd2};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [BUS_W-1:0] in_word = '0;
  logic             clear = 1'b0;
  logic [1:0]       rd_idx = '0;
  logic [CNT_W-1:0] rd_cost;
  logic [TOT_W-1:0] total_cost;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int map_src [BUS_W] = '{2, 0, 3, 1};
  int exp_cnt [NPAIR];
  int exp_tot;
  int last_cost [NPAIR];
  int m_prev [BUS_W];
  bit m_have;

  always #2.5 clk = ~clk;

  coupling_monitor #(.BUS_W(BUS_W), .CNT_W(CNT_W), .TOT_W(TOT_W), .TRACK_MAP(MAP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .clear(clear),
    .rd_idx(rd_idx), .rd_cost(rd_cost), .total_cost(total_cost)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int p = 0; p < NPAIR; p++) begin exp_cnt[p] = 0; last_cost[p] = 0; end
    exp_tot = 0;
    m_have = 1'b0;
  endtask

  task automatic model_word(input logic [BUS_W-1:0] w);
    int nw [BUS_W];
    for (int t = 0; t < BUS_W; t++) nw[t] = int'(w[map_src[t]]);
    for (int p = 0; p < NPAIR; p++) begin
      int da;
      int db;
      da = nw[p] - m_prev[p];
      db = nw[p+1] - m_prev[p+1];
      last_cost[p] = m_have ? (da - db) * (da - db) : 0;
      exp_cnt[p] = (exp_cnt[p] + last_cost[p] > CMAX) ? CMAX : exp_cnt[p] + last_cost[p];
      exp_tot = (exp_tot + last_cost[p]) % (1 << TOT_W);
    end
    for (int t = 0; t < BUS_W; t++) m_prev[t] = nw[t];
    m_have = 1'b1;
  endtask

  task automatic send(input logic [BUS_W-1:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    model_word(w);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
  endtask

  task automatic read_pair(input int idx, output int val);
    @(negedge clk);
    rd_idx = 2'(idx);
    @(negedge clk);
    val = int'(rd_cost);
  endtask

  function automatic string cost_tag(input int c);
    if (c == 1) return "R2 single toggle";
    if (c == 4) return "R4 opposite";
    return "R3/R5 zero-cost";
  endfunction

  initial begin
    int v;
    model_clear();
    for (int t = 0; t < BUS_W; t++) m_prev[t] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 total after reset", int'(total_cost), 0);
    check("R1 rd_cost after reset", int'(rd_cost), 0);
    for (int p = 0; p < NPAIR; p++) begin
      read_pair(p, v);
      check("R1 pair after reset", v, 0);
    end

    // Exhaustive word pairs from a fresh clear
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_clear();
        send(4'(a));
        check("R6 first word charges nothing", int'(total_cost), 0);
        send(4'(b));
        check("R9 total of one transition", int'(total_cost), exp_tot);
        for (int p = 0; p < NPAIR; p++) begin
          read_pair(p, v);
          check(cost_tag(last_cost[p]), v, exp_cnt[p]);
        end
      end
    end

    // R7 track order: 0001 -> 0100 gives pair costs 4,1,0
    do_clear();
    send(4'b0001);
    send(4'b0100);
    read_pair(0, v); check("R7 pair0 mapped", v, 4);
    read_pair(1, v); check("R7 pair1 mapped", v, 1);
    read_pair(2, v); check("R7 pair2 mapped", v, 0);
    check("R7 total mapped", int'(total_cost), 5);

    // Long stream with idle cycles: saturation and total
    do_clear();
    for (int i = 0; i < 300; i++) begin
      send(4'((i * 7 + 3) % 16));
      if (i % 3 == 0) begin
        v = int'(total_cost);
        @(negedge clk);
        in_word = 4'((i * 5 + 1) % 16);
        @(negedge clk);
        check("R5 idle cycle leaves total", int'(total_cost), v);
      end
    end
    for (int p = 0; p < NPAIR; p++) begin
      read_pair(p, v);
      check("R8 saturated pair counter", v, exp_cnt[p]);
    end
    check("R9 long-run total", int'(total_cost), exp_tot);
    // R5: the idle words must not have become the previous word
    send(4'((299 * 7 + 3) % 16));
    check("R5 idle word not stored", int'(total_cost), exp_tot);

    // R11 out-of-range index and latency
    read_pair(3, v);
    check("R11 out-of-range index", v, 0);
    read_pair(0, v);
    check("R11 one-cycle read", v, exp_cnt[0]);

    // R10 clear with a simultaneous valid word
    @(negedge clk);
    clear = 1'b1;
    in_valid = 1'b1;
    in_word = 4'b1111;
    @(negedge clk);
    clear = 1'b0;
    in_valid = 1'b0;
    model_clear();
    check("R10 total cleared", int'(total_cost), 0);
    for (int p = 0; p < NPAIR; p++) begin
      read_pair(p, v);
      check("R10 pair cleared", v, 0);
    end
    send(4'b0000);
    check("R10 word during clear dropped", int'(total_cost), 0);
    send(4'b0110);
    check("R10 charging resumes", int'(total_cost), exp_tot);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule